// File: doc/BRIEF.md
# Multi-Level Concurrent Trigger Sequencer

This block decides when a logic-capture engine should trigger and whether each sample should be kept. It holds twelve sequence levels. Any set of them, up to all twelve, can be live in the same cycle, and each live level watches its own event condition. The conditions are built from a vector of pattern-match terms that arrives once per sample. When a live level's event occurs, it can wake other levels, raise the trigger, or both. A level can also be marked one-shot, which makes it retire itself when its event occurs. Two levels are event counters with an "A and not B" qualifier. Two are timers that measure how long they have been live. The remaining eight wait for a single selected term.

While a level is live it can push the capture engine toward keeping samples or toward discarding them, and it can switch on the capture filter. These outputs are the OR of the contributions of every live level. When two levels disagree, discard wins. Configuration arrives on static inputs that are loaded before arming. An arm pulse clears all progress, wakes a programmable set of start levels and clears the trigger flag. Once set, the trigger flag stays set until the next arm.

Samples are marked by `sample_valid`. The sequencer evaluates one sample per clock and has no ready output. Every sample is accepted in the cycle it is presented, so no back-pressure reaches the pattern-match stage. Cycles without `sample_valid` change no state.

Top module: `mlt_trig_seq`

## Requirements
- R1: After reset, `active_lvls` is all zero, and `triggered`, `cap_force_on`, `cap_force_off` and `filter_en` are all 0.
- R2: An `arm` pulse loads `active_lvls` with `cfg_start_mask` and clears `triggered` on the next clock edge. Arm takes precedence over a sample presented in the same cycle.
- R3: An event-wait level (levels 0 to 7) fires on a valid sample while it is live and while term `cfg_sel_a[i]` is 1. The levels set in its field `cfg_next_mask[i*12 +: 12]` become live on the following edge.
- R4: When a level fires and its `cfg_one_shot` bit is 0, the level stays live. When that bit is 1, the level leaves the live set, unless some level that fires in the same cycle wakes it again.
- R5: A counter level (levels 8 and 9) counts valid live samples on which term A is 1 and term B (`cfg_sel_b`) is 0. It fires on the qualifying sample that brings the count to its limit, then restarts from zero. A limit of 0 or 1 fires on the first qualifying sample. The limit of level 8+k is `cfg_limit[k*16 +: 16]`.
- R6: A timer level (levels 10 and 11) counts the valid samples it has been live for, starting when it becomes live. It fires on the sample that reaches its limit (limit index 2 and 3), then restarts.
- R7: A live level whose `cfg_fire_trig` bit is 1 sets `triggered` when it fires. `triggered` stays 1 until the next arm.
- R8: The capture mode of level i is `cfg_cap_mode[2i +: 2]`: bit 0 requests keep and bit 1 requests discard. `cap_force_off` is 1 when any live level requests discard. `cap_force_on` is 1 only when some live level requests keep and none requests discard.
- R9: `filter_en` is 1 exactly when at least one live level has its `cfg_filt_en` bit set.
- R10: In a cycle with `sample_valid` low and no arm, `active_lvls` and `triggered` do not change.
- R11: All twelve levels can be live at once, and each one evaluates the same sample independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Clear progress, load start levels, clear trigger flag |
| sample_valid | input | 1 | Marks a sample to evaluate; always accepted |
| terms | input | 8 | Pattern-match term vector for this sample |
| cfg_start_mask | input | 12 | Levels made live by arm |
| cfg_sel_a | input | 36 | Per-level 3-bit index of term A |
| cfg_sel_b | input | 36 | Per-level 3-bit index of term B (counter levels) |
| cfg_next_mask | input | 144 | Per-level 12-bit set of levels woken on fire |
| cfg_fire_trig | input | 12 | Per-level: firing sets the trigger flag |
| cfg_one_shot | input | 12 | Per-level: level retires when it fires |
| cfg_cap_mode | input | 24 | Per-level 2-bit capture request (bit0 keep, bit1 discard) |
| cfg_filt_en | input | 12 | Per-level filter enable while live |
| cfg_limit | input | 64 | 16-bit limits: counters 8, 9 then timers 10, 11 |
| active_lvls | output | 12 | Live level set |
| triggered | output | 1 | Sticky trigger flag |
| cap_force_on | output | 1 | Keep samples |
| cap_force_off | output | 1 | Discard samples |
| filter_en | output | 1 | Capture filter enabled |

## Verification
Two pairs of functions can land in the same cycle. The first pair is an arm pulse and a sample that would retire every one-shot level. The bench raises both in one cycle with all twelve levels live and expects the whole set to stay loaded from the start mask. The second pair is a keep request and a discard request from two levels that are live together. The bench starts both levels from the same arm and expects only the discard output to be high, then removes the discarding level and expects the keep output to return.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  typedef enum logic [1:0] {
    KIND_WAIT  = 2'd0,
    KIND_COUNT = 2'd1,
    KIND_TIMER = 2'd2
  } lvl_kind_e;

  localparam int CAP_KEEP_BIT = 0;
  localparam int CAP_DROP_BIT = 1;
  localparam int CAP_W        = 2;
endpackage

// File: rtl/mlt_level_unit.sv
module mlt_level_unit #(
  parameter mlt_pkg::lvl_kind_e KIND = mlt_pkg::KIND_WAIT,
  parameter int NUM_TERMS = 8,
  parameter int CNT_W     = 16,
  localparam int SEL_W    = $clog2(NUM_TERMS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 sample_valid,
  input  logic                 live,
  input  logic [NUM_TERMS-1:0] terms,
  input  logic [SEL_W-1:0]     sel_a,
  input  logic [SEL_W-1:0]     sel_b,
  input  logic [CNT_W-1:0]     limit,
  output logic                 fire
);
  generate
    if (KIND == mlt_pkg::KIND_WAIT) begin : g_wait
      logic unused_wait;
      assign unused_wait = ^{clk, rst_n, arm, sel_b, limit};
      assign fire = live & sample_valid & terms[sel_a];
    end else begin : g_cnt
      logic             hit;
      logic [CNT_W-1:0] cnt;
      logic [CNT_W:0]   cnt_inc;

      if (KIND == mlt_pkg::KIND_COUNT) begin : g_qual
        assign hit = terms[sel_a] & ~terms[sel_b];
      end else begin : g_time
        logic unused_time;
        assign unused_time = ^{terms, sel_a, sel_b};
        assign hit = 1'b1;
      end

      assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
      assign fire    = live & sample_valid & hit & (cnt_inc >= {1'b0, limit});

      always_ff @(posedge clk) begin
        if (!rst_n || arm || !live) begin
          cnt <= '0;
        end else if (sample_valid && hit) begin
          cnt <= fire ? '0 : cnt_inc[CNT_W-1:0];
        end
      end

      // R5 / R6: progress stays below the limit between firings
      p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (cnt < limit));
    end
  endgenerate
endmodule

// File: rtl/mlt_cap_merge.sv
module mlt_cap_merge #(
  parameter int NUM_LEVELS = 12,
  localparam int CAP_W     = mlt_pkg::CAP_W
) (
  input  logic [NUM_LEVELS-1:0]       live,
  input  logic [NUM_LEVELS*CAP_W-1:0] cap_mode,
  input  logic [NUM_LEVELS-1:0]       filt_bits,
  output logic                        force_on,
  output logic                        force_off,
  output logic                        filt
);
  logic any_keep;
  logic any_drop;

  always_comb begin
    any_keep = 1'b0;
    any_drop = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (live[i]) begin
        any_keep = any_keep | cap_mode[i*CAP_W + mlt_pkg::CAP_KEEP_BIT];
        any_drop = any_drop | cap_mode[i*CAP_W + mlt_pkg::CAP_DROP_BIT];
      end
    end
  end

  assign force_off = any_drop;
  assign force_on  = any_keep & ~any_drop;
  assign filt      = |(live & filt_bits);
endmodule

// File: rtl/mlt_trig_seq.sv
module mlt_trig_seq #(
  parameter int NUM_LEVELS = 12,
  parameter int NUM_CNT    = 2,
  parameter int NUM_TMR    = 2,
  parameter int NUM_TERMS  = 8,
  parameter int CNT_W      = 16,
  localparam int NUM_WAIT  = NUM_LEVELS - NUM_CNT - NUM_TMR,
  localparam int NUM_LIM   = NUM_CNT + NUM_TMR,
  localparam int SEL_W     = $clog2(NUM_TERMS),
  localparam int CAP_W     = mlt_pkg::CAP_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            arm,
  input  logic                            sample_valid,
  input  logic [NUM_TERMS-1:0]            terms,
  input  logic [NUM_LEVELS-1:0]           cfg_start_mask,
  input  logic [NUM_LEVELS*SEL_W-1:0]     cfg_sel_a,
  input  logic [NUM_LEVELS*SEL_W-1:0]     cfg_sel_b,
  input  logic [NUM_LEVELS*NUM_LEVELS-1:0] cfg_next_mask,
  input  logic [NUM_LEVELS-1:0]           cfg_fire_trig,
  input  logic [NUM_LEVELS-1:0]           cfg_one_shot,
  input  logic [NUM_LEVELS*CAP_W-1:0]     cfg_cap_mode,
  input  logic [NUM_LEVELS-1:0]           cfg_filt_en,
  input  logic [NUM_LIM*CNT_W-1:0]        cfg_limit,
  output logic [NUM_LEVELS-1:0]           active_lvls,
  output logic                            triggered,
  output logic                            cap_force_on,
  output logic                            cap_force_off,
  output logic                            filter_en
);
  logic [NUM_LEVELS-1:0] fire;
  logic [NUM_LEVELS-1:0] wake;
  logic [NUM_LEVELS-1:0] live_nx;
  logic                  trig_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LEVELS; gi++) begin : g_lvl
      if (gi < NUM_WAIT) begin : g_w
        mlt_level_unit #(
          .KIND(mlt_pkg::KIND_WAIT), .NUM_TERMS(NUM_TERMS), .CNT_W(CNT_W)
        ) u_unit (
          .clk(clk), .rst_n(rst_n), .arm(arm), .sample_valid(sample_valid),
          .live(active_lvls[gi]), .terms(terms),
          .sel_a(cfg_sel_a[gi*SEL_W +: SEL_W]),
          .sel_b(cfg_sel_b[gi*SEL_W +: SEL_W]),
          .limit({CNT_W{1'b0}}), .fire(fire[gi])
        );
      end else begin : g_c
        localparam int LI = gi - NUM_WAIT;
        localparam mlt_pkg::lvl_kind_e K =
          (LI < NUM_CNT) ? mlt_pkg::KIND_COUNT : mlt_pkg::KIND_TIMER;
        mlt_level_unit #(
          .KIND(K), .NUM_TERMS(NUM_TERMS), .CNT_W(CNT_W)
        ) u_unit (
          .clk(clk), .rst_n(rst_n), .arm(arm), .sample_valid(sample_valid),
          .live(active_lvls[gi]), .terms(terms),
          .sel_a(cfg_sel_a[gi*SEL_W +: SEL_W]),
          .sel_b(cfg_sel_b[gi*SEL_W +: SEL_W]),
          .limit(cfg_limit[LI*CNT_W +: CNT_W]), .fire(fire[gi])
        );
      end
    end
  endgenerate

  always_comb begin
    wake     = '0;
    trig_hit = 1'b0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (fire[i]) begin
        wake     = wake | cfg_next_mask[i*NUM_LEVELS +: NUM_LEVELS];
        trig_hit = trig_hit | cfg_fire_trig[i];
      end
    end
    live_nx = (active_lvls & ~(fire & cfg_one_shot)) | wake;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_lvls <= '0;
      triggered   <= 1'b0;
    end else if (arm) begin
      active_lvls <= cfg_start_mask;
      triggered   <= 1'b0;
    end else if (sample_valid) begin
      active_lvls <= live_nx;
      triggered   <= triggered | trig_hit;
    end
  end

  mlt_cap_merge #(.NUM_LEVELS(NUM_LEVELS)) u_cap (
    .live(active_lvls), .cap_mode(cfg_cap_mode), .filt_bits(cfg_filt_en),
    .force_on(cap_force_on), .force_off(cap_force_off), .filt(filter_en)
  );

  p_arm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (active_lvls == $past(cfg_start_mask)) && !triggered);

  p_trig_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> triggered);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !sample_valid) |=> $stable(active_lvls) && $stable(triggered));

  p_cap_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_force_on && cap_force_off));
endmodule

// File: tb/mlt_trig_seq_bench.sv
module mlt_trig_seq_bench;
  localparam int L = 12, TW = 8, SW = 3, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, sample_valid = 1'b0;
  logic [TW-1:0]   terms = '0;
  logic [L-1:0]    cfg_start_mask, cfg_fire_trig, cfg_one_shot, cfg_filt_en;
  logic [L*SW-1:0] cfg_sel_a, cfg_sel_b;
  logic [L*L-1:0]  cfg_next_mask;
  logic [L*2-1:0]  cfg_cap_mode;
  logic [4*CW-1:0] cfg_limit;
  logic [L-1:0]    active_lvls;
  logic triggered, cap_force_on, cap_force_off, filter_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mlt_trig_seq u_mlt_trig_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sample_valid(sample_valid),
    .terms(terms), .cfg_start_mask(cfg_start_mask), .cfg_sel_a(cfg_sel_a),
    .cfg_sel_b(cfg_sel_b), .cfg_next_mask(cfg_next_mask),
    .cfg_fire_trig(cfg_fire_trig), .cfg_one_shot(cfg_one_shot),
    .cfg_cap_mode(cfg_cap_mode), .cfg_filt_en(cfg_filt_en),
    .cfg_limit(cfg_limit), .active_lvls(active_lvls), .triggered(triggered),
    .cap_force_on(cap_force_on), .cap_force_off(cap_force_off),
    .filter_en(filter_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic samp(input logic [TW-1:0] t, input logic v);
    terms = t; sample_valid = v;
    @(negedge clk);
    terms = '0; sample_valid = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic clear_cfg();
    cfg_start_mask = '0; cfg_fire_trig = '0; cfg_one_shot = '0;
    cfg_filt_en = '0; cfg_sel_a = '0; cfg_sel_b = '0; cfg_next_mask = '0;
    cfg_cap_mode = '0;
    do_arm();
    cfg_limit = '0;
  endtask

  task automatic set_lvl(input int i, input int a, input int b,
                         input logic [L-1:0] nxt, input bit trg, input bit os);
    cfg_sel_a[i*SW +: SW] = SW'(a);
    cfg_sel_b[i*SW +: SW] = SW'(b);
    cfg_next_mask[i*L +: L] = nxt;
    cfg_fire_trig[i] = trg;
    cfg_one_shot[i] = os;
  endtask

  task automatic t_reset();
    chk("R1 live set", 32'(active_lvls), 0);
    chk("R1 trigger", 32'(triggered), 0);
    chk("R1 capture", {30'd0, cap_force_on, cap_force_off}, 0);
    chk("R1 filter", 32'(filter_en), 0);
  endtask

  task automatic t_chain();
    clear_cfg();
    set_lvl(0, 0, 0, 12'h002, 0, 0);
    set_lvl(1, 1, 0, 12'h000, 1, 0);
    cfg_start_mask = 12'h001;
    do_arm();
    chk("R2 start load", 32'(active_lvls), 32'h001);
    samp(8'h01, 1);
    chk("R3 wake next", 32'(active_lvls), 32'h003);
    chk("R3 no trigger yet", 32'(triggered), 0);
    samp(8'h02, 1);
    chk("R7 trigger set", 32'(triggered), 1);
    samp(8'h00, 1);
    chk("R7 trigger sticky", 32'(triggered), 1);
    chk("R4 stays live", 32'(active_lvls), 32'h003);
    do_arm();
    chk("R2 arm clears trigger", 32'(triggered), 0);
    chk("R2 arm reloads", 32'(active_lvls), 32'h001);
  endtask

  task automatic t_one_shot();
    clear_cfg();
    set_lvl(2, 2, 0, 12'h008, 0, 1);
    cfg_start_mask = 12'h004;
    do_arm();
    samp(8'h04, 1);
    chk("R4 one-shot retires", 32'(active_lvls), 32'h008);
  endtask

  task automatic t_counter();
    clear_cfg();
    set_lvl(8, 4, 5, 12'h000, 1, 0);
    cfg_limit[0 +: CW] = 16'd3;
    cfg_start_mask = 12'h100;
    do_arm();
    samp(8'h30, 1);
    samp(8'h10, 1);
    samp(8'h10, 1);
    samp(8'h00, 1);
    chk("R5 below limit", 32'(triggered), 0);
    samp(8'h10, 1);
    chk("R5 fires at limit", 32'(triggered), 1);
  endtask

  task automatic t_counter_one();
    clear_cfg();
    set_lvl(9, 4, 5, 12'h000, 1, 0);
    cfg_limit[CW +: CW] = 16'd1;
    cfg_start_mask = 12'h200;
    do_arm();
    samp(8'h30, 1);
    chk("R5 A with B no count", 32'(triggered), 0);
    samp(8'h10, 1);
    chk("R5 limit one fires", 32'(triggered), 1);
  endtask

  task automatic t_timer();
    clear_cfg();
    set_lvl(10, 0, 0, 12'h000, 1, 0);
    cfg_limit[2*CW +: CW] = 16'd4;
    cfg_start_mask = 12'h400;
    do_arm();
    samp(8'h00, 1);
    samp(8'h00, 0);
    samp(8'h00, 1);
    samp(8'h00, 0);
    samp(8'h00, 1);
    chk("R6 three samples", 32'(triggered), 0);
    samp(8'h00, 1);
    chk("R6 fires at limit", 32'(triggered), 1);
  endtask

  task automatic t_capture();
    clear_cfg();
    cfg_cap_mode[0 +: 2] = 2'b01;
    cfg_cap_mode[2 +: 2] = 2'b10;
    cfg_filt_en[1] = 1'b1;
    cfg_start_mask = 12'h003;
    do_arm();
    chk("R8 discard wins", {30'd0, cap_force_on, cap_force_off}, 32'h1);
    chk("R9 filter on", 32'(filter_en), 1);
    cfg_start_mask = 12'h001;
    do_arm();
    chk("R8 keep alone", {30'd0, cap_force_on, cap_force_off}, 32'h2);
    chk("R9 filter off", 32'(filter_en), 0);
    cfg_cap_mode[0 +: 2] = 2'b11;
    #1;
    chk("R8 both bits discard", {30'd0, cap_force_on, cap_force_off}, 32'h1);
  endtask

  task automatic t_concurrent();
    clear_cfg();
    for (int i = 0; i < L; i++) set_lvl(i, 0, 0, 12'h000, 0, 1);
    cfg_start_mask = 12'hFFF;
    do_arm();
    chk("R11 all live", 32'(active_lvls), 32'hFFF);
    arm = 1'b1; terms = 8'h01; sample_valid = 1'b1;
    @(negedge clk);
    arm = 1'b0; terms = '0; sample_valid = 1'b0;
    chk("R2 arm beats sample", 32'(active_lvls), 32'hFFF);
    samp(8'h01, 1);
    chk("R11 parallel evaluation", 32'(active_lvls), 32'h300);
  endtask

  task automatic t_hold();
    clear_cfg();
    set_lvl(0, 0, 0, 12'h000, 1, 1);
    cfg_start_mask = 12'h001;
    do_arm();
    samp(8'h01, 0);
    chk("R10 no sample keeps live", 32'(active_lvls), 32'h001);
    chk("R10 no sample no trigger", 32'(triggered), 0);
    samp(8'h01, 1);
    chk("R10 sample then acts", {31'd0, triggered}, 1);
    chk("R4 one-shot gone", 32'(active_lvls), 0);
  endtask

  initial begin
    cfg_start_mask = '0; cfg_fire_trig = '0; cfg_one_shot = '0;
    cfg_filt_en = '0; cfg_sel_a = '0; cfg_sel_b = '0; cfg_next_mask = '0;
    cfg_cap_mode = '0; cfg_limit = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chain();
    t_one_shot();
    t_counter();
    t_counter_one();
    t_timer();
    t_capture();
    t_concurrent();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule